// File: doc/BRIEF.md
# Multi-State CPU Sequencing Controller

This block is the control sequencer of a small load/store processor. It walks a fixed cycle of states: it reads a 20-bit instruction word from memory into its instruction register, inspects the opcode in the next cycle, and then runs one execute state: a register move, an arithmetic/logic operation or a memory access. After the execute state it returns to reading. The block holds the program counter, the instruction register, a register file of 63 general registers, and a status register. The status register sits at register address 63 and can be used like any other operand outside memory operations.

Arithmetic is done by an external combinational unit. The sequencer drives that unit's two operands and a function code, and it writes the unit's result back into the register file. Memory is one shared port. The sequencer holds a request, an address, a write strobe and write data. The memory either answers with a ready pulse, or the sequencer assumes the access is done once an internal 3-bit step counter reaches its last value, whichever comes first.

Instruction layout: opcode in bits [3:0], destination/first register in [9:4], second register in [15:10], and bits [19:16] reserved (written as zero). Opcodes: 0 OR, 1 AND, 2 NAND, 3 NOR, 4 XOR, 5 XNOR, 6 ADD, 7 SUB (first minus second), 8 NOT, 9 INC, 10 DEC, 11 MOVE, 12 LOAD, 13 STORE, 14 and 15 no operation.

Top module: `cpu_seq_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the program counter, the instruction register, the step counter and the status register, and puts the sequencer in the read state, so the first access is a read of address 0.
- R2: A read holds mem_req high with mem_addr equal to the program counter and mem_we low. It ends on the first cycle in which mem_rdy is high, or on its 8th cycle if mem_rdy never comes. At that point the word on mem_rdata is captured and the program counter advances by exactly one, so consecutive reads use consecutive addresses.
- R3: After each read comes exactly one decode cycle with mem_req low. Opcodes 14 and 15 then return straight to reading, so the next read starts after one idle cycle.
- R4: MOVE (opcode 11) copies register [15:10] into register [9:4]. It takes one decode cycle and one execute cycle (two idle cycles) and then starts the next read.
- R5: Opcodes 0 to 7 present register [9:4] on alu_a and register [15:10] on alu_b, with alu_fn equal to the opcode, and write alu_y into register [9:4]. They take two idle cycles.
- R6: Opcodes 8 to 10 present register [15:10] on alu_a and zero on alu_b, and write alu_y into register [9:4].
- R7: Register address 63 selects the status register. It reads as zero after reset and can be read and written by MOVE and by all arithmetic/logic opcodes.
- R8: LOAD (opcode 12) issues an access with mem_addr equal to register [15:10] and mem_we low. It uses the same ready-or-8th-cycle end rule, writes mem_rdata[7:0] into register [9:4], and then reading resumes with no idle cycle.
- R9: STORE (opcode 13) issues an access with mem_addr equal to register [15:10], mem_we high and mem_wdata equal to register [9:4], under the same end rule. Reading then resumes with no idle cycle.
- R10: A LOAD or STORE that names register 63 in either field makes no memory access and returns to reading after the single decode cycle.
- R11: mem_we is high only during a store access, and mem_req is low in decode, move and arithmetic cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Memory access in progress |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (8) | Access address |
| mem_wdata | output | DW (8) | Write data |
| mem_rdata | input | 20 | Read data / instruction word |
| mem_rdy | input | 1 | Memory completes the access this cycle |
| alu_a | output | DW (8) | First operand to the external unit |
| alu_b | output | DW (8) | Second operand to the external unit |
| alu_fn | output | 4 | Function code (the opcode) |
| alu_y | input | DW (8) | Result from the external unit |

## Verification
The two end conditions of an access can fall on the same cycle: the memory ready pulse and the step counter reaching its last value. The bench provokes this by holding mem_rdy off until exactly the 8th cycle of a read or data access. Other accesses get ready on the first cycle, on a random cycle, or never. Every case is judged the same way: the next access address must show a single program-counter step, and the length of the idle gap must match the opcode. A reference model of the registers, driven by the same memory image, predicts every access address, strobe and store value.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

    localparam int IW  = 20;
    localparam int OPW = 4;
    localparam int RAW = 6;
    localparam logic [RAW-1:0] SR_ADDR = '1;

    typedef enum logic [OPW-1:0] {
        OP_OR, OP_AND, OP_NAND, OP_NOR, OP_XOR, OP_XNOR, OP_ADD, OP_SUB,
        OP_NOT, OP_INC, OP_DEC, OP_MOVE, OP_LOAD, OP_STORE, OP_NOPA, OP_NOPB
    } opcode_e;

    typedef struct packed {
        logic [IW-OPW-2*RAW-1:0] rsv;
        logic [RAW-1:0]          src;
        logic [RAW-1:0]          dst;
        logic [OPW-1:0]          op;
    } instr_t;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_ALU, ST_MOVE, ST_MEM
    } seq_state_e;

    typedef enum logic [2:0] {
        K_NOP, K_ALU, K_MOVE, K_LOAD, K_STORE
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  unary;
    } dec_t;

    function automatic dec_t decode_op(instr_t i);
        dec_t d;
        logic touches_sr;
        touches_sr = (i.dst == SR_ADDR) || (i.src == SR_ADDR);
        d.unary = 1'b0;
        case (opcode_e'(i.op))
            OP_NOT, OP_INC, OP_DEC: begin
                d.kind  = K_ALU;
                d.unary = 1'b1;
            end
            OP_MOVE:  d.kind = K_MOVE;
            OP_LOAD:  d.kind = touches_sr ? K_NOP : K_LOAD;
            OP_STORE: d.kind = touches_sr ? K_NOP : K_STORE;
            OP_NOPA, OP_NOPB: d.kind = K_NOP;
            default:  d.kind = K_ALU;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
    parameter int TW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ready,
    output logic done
);
    localparam logic [TW-1:0] LAST = '1;

    logic [TW-1:0] cnt;

    assign done = run && (ready || cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) cnt <= '0;
        else                        cnt <= cnt + TW'(1);
    end

    // R2: an access never runs past the last count without finishing
    a_r2_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == LAST) |=> (cnt == '0));

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [$clog2(NREG)-1:0] ra_a,
    output logic [DW-1:0]           rd_a,
    input  logic [$clog2(NREG)-1:0] ra_b,
    output logic [DW-1:0]           rd_b
);
    localparam int RW = $clog2(NREG);
    localparam logic [RW-1:0] SRX = RW'(NREG - 1);

    logic [DW-1:0] gpr [NREG-1];
    logic [DW-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                  sr_q <= '0;
        else if (we && waddr == SRX) sr_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (we && waddr != SRX) gpr[waddr] <= wdata;
    end

    assign rd_a = (ra_a == SRX) ? sr_q : gpr[ra_a];
    assign rd_b = (ra_b == SRX) ? sr_q : gpr[ra_b];

    // R7: status register leaves reset at zero
    a_r7_sr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sr_q == '0));

endmodule

// File: rtl/seq_decoder.sv
module seq_decoder
    import cpu_seq_pkg::*;
(
    input  instr_t ir,
    output dec_t   dec
);
    assign dec = decode_op(ir);
endmodule

// File: rtl/cpu_seq_ctrl.sv
module cpu_seq_ctrl
    import cpu_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [IW-1:0] mem_rdata,
    input  logic          mem_rdy,
    output logic [DW-1:0] alu_a,
    output logic [DW-1:0] alu_b,
    output logic [OPW-1:0] alu_fn,
    input  logic [DW-1:0] alu_y
);
    localparam int NREG = 2 ** RAW;

    seq_state_e    state;
    instr_t        ir;
    logic [AW-1:0] pc;
    dec_t          dec;
    logic          run, done;
    logic          rf_we;
    logic [DW-1:0] rf_wdata, rd_a, rd_b;

    seq_decoder u_dec (.ir(ir), .dec(dec));

    assign run = (state == ST_FETCH) || (state == ST_MEM);

    seq_step_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .ready(mem_rdy), .done(done)
    );

    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = alu_y;
        case (state)
            ST_ALU:  rf_we = 1'b1;
            ST_MOVE: begin
                rf_we    = 1'b1;
                rf_wdata = rd_b;
            end
            ST_MEM: begin
                rf_we    = done && (dec.kind == K_LOAD);
                rf_wdata = mem_rdata[DW-1:0];
            end
            default: ;
        endcase
    end

    seq_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .waddr(ir.dst), .wdata(rf_wdata),
        .ra_a(ir.dst), .rd_a(rd_a),
        .ra_b(ir.src), .rd_b(rd_b)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            ir    <= '0;
            pc    <= '0;
        end else begin
            case (state)
                ST_FETCH: if (done) begin
                    ir    <= instr_t'(mem_rdata);
                    pc    <= pc + AW'(1);
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    case (dec.kind)
                        K_ALU:            state <= ST_ALU;
                        K_MOVE:           state <= ST_MOVE;
                        K_LOAD, K_STORE:  state <= ST_MEM;
                        default:          state <= ST_FETCH;
                    endcase
                end
                ST_MEM:  if (done) state <= ST_FETCH;
                default: state <= ST_FETCH;
            endcase
        end
    end

    assign mem_req   = run;
    assign mem_we    = (state == ST_MEM) && (dec.kind == K_STORE);
    assign mem_addr  = (state == ST_FETCH) ? pc : AW'(rd_b);
    assign mem_wdata = rd_a;
    assign alu_fn    = ir.op;
    assign alu_a     = dec.unary ? rd_b : rd_a;
    assign alu_b     = dec.unary ? '0 : rd_b;

    // R2: a completed read advances the program counter by one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && done) |=> (pc == $past(pc) + AW'(1)));

    // R2: the instruction register changes only on a read
    a_r2_ir_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FETCH) |=> $stable(ir));

    // R3: decode lasts a single cycle
    a_r3_decode_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |=> (state != ST_DECODE));

    // R10: memory op naming the status register goes straight back to reading
    a_r10_sr_mem_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && (ir.op == OP_LOAD || ir.op == OP_STORE)
         && (ir.dst == SR_ADDR || ir.src == SR_ADDR)) |=> (state == ST_FETCH));

    // R11: a write strobe always comes with a request
    a_r11_we_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

endmodule

// File: tb/cpu_seq_ctrl_test.sv
module cpu_seq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, mem_rdy;
    logic [7:0]  mem_addr, mem_wdata, alu_a, alu_b, alu_y;
    logic [19:0] mem_rdata;
    logic [3:0]  alu_fn;

    logic [19:0] mem [256];

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] ref_alu(logic [7:0] a, logic [7:0] b, logic [3:0] fn);
        case (fn)
            4'd0:  return a | b;
            4'd1:  return a & b;
            4'd2:  return ~(a & b);
            4'd3:  return ~(a | b);
            4'd4:  return a ^ b;
            4'd5:  return ~(a ^ b);
            4'd6:  return a + b;
            4'd7:  return a - b;
            4'd8:  return ~a;
            4'd9:  return a + 8'd1;
            4'd10: return a - 8'd1;
            default: return 8'd0;
        endcase
    endfunction

    assign alu_y     = ref_alu(alu_a, alu_b, alu_fn);
    assign mem_rdata = mem[mem_addr];

    cpu_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .alu_a(alu_a), .alu_b(alu_b), .alu_fn(alu_fn), .alu_y(alu_y)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] pick_reg();
        int r;
        r = $urandom % 9;
        return (r == 8) ? 6'd63 : 6'(r);
    endfunction

    // reference model state
    logic [7:0] m_r [64];
    string      m_tag [64];
    logic [7:0] m_pc;
    bit         exp_data;
    logic [7:0] exp_addr, exp_wd;
    bit         exp_we;
    logic [5:0] exp_dst;
    string      dtag, gtag;
    int         exp_gap;

    initial begin
        int  gap, ncyc, tgt, done_cnt, idle, cyc;
        bit  in_txn, first;
        logic [19:0] ins;
        logic [3:0]  op;
        logic [5:0]  d, s;

        void'($urandom(32'd4217));
        mem_rdy = 1'b0;
        for (int i = 0; i < 8; i++) mem[i] = {4'h0, 6'd63, 6'(i), 4'd11};
        mem[8]  = {4'h0, 6'd0,  6'd63, 4'd12};
        mem[9]  = {4'h0, 6'd63, 6'd63, 4'd9};
        mem[10] = {4'h0, 6'd63, 6'd1,  4'd11};
        mem[11] = {4'h0, 6'd2,  6'd1,  4'd13};
        for (int i = 12; i < 256; i++)
            mem[i] = {4'h0, pick_reg(), pick_reg(), 4'($urandom % 16)};
        for (int i = 0; i < 64; i++) begin
            m_r[i] = 8'h00;
            m_tag[i] = "R1";
        end
        m_pc = 8'h00; exp_data = 1'b0; exp_gap = 0; gtag = "R1";
        gap = 0; ncyc = 0; tgt = 0; done_cnt = 0; idle = 0; cyc = 0;
        in_txn = 1'b0; first = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        while (done_cnt < 4000) begin
            cyc++;
            if (!mem_req) begin
                mem_rdy = 1'b0;
                gap++;
                idle++;
            end else begin
                if (!in_txn) begin
                    in_txn = 1'b1;
                    ncyc = 0;
                    chk(gap == exp_gap, gtag, gap, exp_gap);
                    if (exp_data) begin
                        chk(mem_addr == exp_addr, dtag, mem_addr, exp_addr);
                        chk(mem_we == exp_we, "R11", mem_we, exp_we);
                        if (exp_we) chk(mem_wdata == exp_wd, m_tag[exp_dst], mem_wdata, exp_wd);
                    end else begin
                        chk(mem_addr == m_pc, first ? "R1" : "R2", mem_addr, m_pc);
                        chk(mem_we == 1'b0, "R11", mem_we, 0);
                    end
                    first = 1'b0;
                    case ($urandom % 4)
                        0: tgt = 99;
                        1: tgt = 8;
                        2: tgt = 1 + ($urandom % 7);
                        default: tgt = 1;
                    endcase
                end
                ncyc++;
                mem_rdy = (ncyc == tgt);
                if (ncyc == tgt || ncyc == 8) begin
                    in_txn = 1'b0;
                    gap = 0;
                    idle = 0;
                    done_cnt++;
                    if (exp_data) begin
                        if (exp_we) mem[exp_addr] = {12'h000, exp_wd};
                        else begin
                            m_r[exp_dst]   = mem[exp_addr][7:0];
                            m_tag[exp_dst] = "R8";
                        end
                        exp_data = 1'b0;
                        exp_gap = 0;
                        gtag = dtag;
                    end else begin
                        ins = mem[m_pc];
                        m_pc = m_pc + 8'd1;
                        op = ins[3:0]; d = ins[9:4]; s = ins[15:10];
                        exp_gap = 2;
                        if (op <= 4'd7) begin
                            m_r[d] = ref_alu(m_r[d], m_r[s], op);
                            m_tag[d] = (d == 63 || s == 63) ? "R7" : "R5";
                            gtag = "R5";
                        end else if (op <= 4'd10) begin
                            m_r[d] = ref_alu(m_r[s], 8'd0, op);
                            m_tag[d] = (d == 63 || s == 63) ? "R7" : "R6";
                            gtag = "R6";
                        end else if (op == 4'd11) begin
                            m_r[d] = m_r[s];
                            m_tag[d] = (d == 63 || s == 63) ? "R7" : "R4";
                            gtag = "R4";
                        end else if (op == 4'd12 || op == 4'd13) begin
                            exp_gap = 1;
                            if (d == 63 || s == 63) gtag = "R10";
                            else begin
                                exp_data = 1'b1;
                                exp_addr = m_r[s];
                                exp_we   = (op == 4'd13);
                                exp_wd   = m_r[d];
                                exp_dst  = d;
                                dtag     = exp_we ? "R9" : "R8";
                                gtag     = "R3";
                            end
                        end else begin
                            exp_gap = 1;
                            gtag = "R3";
                        end
                    end
                end
            end
            if (idle > 20 || cyc > 150000) begin
                chk(1'b0, "watchdog", idle, 0);
                break;
            end
            @(negedge clk);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule